// File: doc/BRIEF.md
# Byte-Buffered Serial Port on an APB Register Bus

This block is a memory-mapped serial port for a peripheral bus with APB-style transfers. Software writes a byte into a one-byte transmit holding register. A serial engine sends it as an 8N1 frame: the line idles high, then come one low start bit, eight data bits with the LSB first, and one high stop bit. A matching receiver watches the input line for a falling start edge. It samples each bit at mid-bit and places each well-framed byte into a one-byte receive holding register, which software drains by reading the data word. Both engines take their bit time from a programmable divider counted in bus clocks. They stay idle while the divider is below its minimum.

Status flags record whether each holding register is full and whether an overrun occurred. Transmit-done and receive interrupt flags are latched. The two overrun interrupt flags are live products of the overrun status and their enables. Five interrupt lines leave the block: one per interrupt flag, plus their OR. A block of read-only identification words near the top of the 4 KiB window carries a part number and revision.

Register map (byte offsets): 0x000 data, 0x004 status, 0x008 control, 0x00C interrupt flags, 0x010 divider, 0xFD0 to 0xFFC identification words. Reads of any other offset return 0, and writes to them are dropped. Every transfer completes in its access cycle.

Top module: `apb_byte_uart`

## Requirements
- R1: After reset, the status, control, interrupt, divider and data words all read 0, `txd` is high and all five interrupt outputs are low.
- R2: The control word keeps only bits 6:0, where bit0 is transmit enable, bit1 receive enable, bit2 transmit interrupt enable, bit3 receive interrupt enable, bit4 transmit-overrun interrupt enable, bit5 receive-overrun interrupt enable and bit6 a test-mode bit that is only stored. The divider keeps only bits 19:0. Both read back what was kept.
- R3: A data write while status bit0 (transmit full) is clear loads the byte and sets status bit0. With transmit enabled and a valid divider, `txd` then carries a frame of a low start bit, data bits LSB first and a high stop bit, each bit lasting exactly divider-value clocks.
- R4: When the stop bit ends, status bit0 clears. Interrupt bit0 sets only if control bit2 is 1.
- R5: A data write while status bit0 is set sets status bit2 (transmit overrun) and drops the new byte. The frame in flight is unchanged and no further frame follows.
- R6: A received frame whose stop bit is high stores the byte, sets status bit1 (receive full), and sets interrupt bit1 only if control bit3 is 1.
- R7: A frame that arrives while status bit1 is set sets status bit3 (receive overrun) and overwrites the stored byte.
- R8: With receive disabled, frames on `rxd` change nothing. A frame whose stop bit is low is discarded, and the receiver takes the next good frame.
- R9: Reading the data word returns the stored received byte and clears status bit1.
- R10: Interrupt bit2 always equals status bit2 AND control bit4, and interrupt bit3 always equals status bit3 AND control bit5, following control changes with no write to the flags.
- R11: Writing 1s to status bits 2 or 3 clears them, and status bits 0 and 1 ignore writes. Writing 1s to the interrupt word clears the matching latched bits, and a 1 in bit2 or bit3 clears the matching status overrun bit.
- R12: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow interrupt bits 0 to 3 in that order, and `irq_any` is their OR.
- R13: While the divider is below 16, neither engine runs: a loaded byte stays pending with `txd` high, and incoming frames are not stored. A pending byte is sent once a valid divider is written.
- R14: Identification word n at offset 0xFD0+4n reads the part number's bits 7:0 when n=4, reads {revision, part number bits 11:8} when n=5, and reads 0 otherwise. Writes to identification words and reads of unmapped offsets have no effect and return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and engine clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 12 | Byte address within the 4 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line, idles high |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit-overrun interrupt |
| irq_rxovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of the four interrupt lines |

## Verification
The bench aims at the moments when the two holding registers and their flags collide. A design that overwrote the transmit byte on an overrun would send the second byte, or send two frames, instead of one frame with the first byte. A design that latched the overrun interrupts would keep `irq_txovr` high after its enable drops. A design that let status writes touch bits 0 and 1 would lose the full flags. The bench also programs a divider below the minimum with a byte pending. An engine that ran anyway would toggle `txd`, and one that never recovered would not send the byte once the divider becomes valid. A frame with a low stop bit must leave no trace, and the following good frame must still arrive.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

  // Word addresses (byte offset >> 2) inside the 4 KiB window
  localparam int WA_DATA     = 'h000;
  localparam int WA_STAT     = 'h001;
  localparam int WA_CTRL     = 'h002;
  localparam int WA_INT      = 'h003;
  localparam int WA_DIV      = 'h004;
  localparam int WA_ID_FIRST = 'h3F4;
  localparam int WA_ID_LAST  = 'h3FF;

  localparam int CTRL_W = 7;

  // Field order fixes the bit positions software sees (bit6 down to bit0)
  typedef struct packed {
    logic test_mode;
    logic rxo_ie;
    logic txo_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // A divider is usable only from the minimum upwards
  function automatic logic div_valid(logic [31:0] div, logic [31:0] min_div);
    return div >= min_div;
  endfunction

  // Counter reload for one full bit period
  function automatic logic [31:0] bit_reload(logic [31:0] div);
    return div - 32'd1;
  endfunction

  // Counter reload from the start edge to the middle of the start bit
  function automatic logic [31:0] half_reload(logic [31:0] div);
    return (div >> 1) - 32'd1;
  endfunction

  // Identification byte for word n of the ID block
  function automatic logic [7:0] id_byte(int n, logic [11:0] part, logic [3:0] rev);
    case (n)
      4:       return part[7:0];
      5:       return {rev, part[11:8]};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/byte_uart_sync.sv
module byte_uart_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/byte_uart_tx.sv
module byte_uart_tx
  import byte_uart_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [DIV_W-1:0]  div,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic               bit_end;
  logic               last_bit;
  logic [DIV_W-1:0]   reload;

  assign reload   = DIV_W'(bit_reload(32'(div)));
  assign bit_end  = busy && (cnt == '0);
  assign last_bit = (idx == IDX_W'(FRAME_W - 1));
  assign done     = run && bit_end && last_bit;
  assign txd      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      idx   <= '0;
    end else if (!run) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        shreg <= {1'b1, data, 1'b0};
        cnt   <= reload;
        idx   <= '0;
      end
    end else if (bit_end) begin
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        cnt   <= reload;
        idx   <= idx + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx
  import byte_uart_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rxd_s,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e          st;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               prev;
  logic               fall;
  logic               tick;

  assign fall = prev && !rxd_s;
  assign tick = (cnt == '0);
  assign busy = (st != RX_IDLE);
  assign done = run && (st == RX_STOP) && tick && rxd_s;
  assign data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      prev  <= 1'b1;
    end else begin
      prev <= rxd_s;
      if (!run) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: begin
            if (fall) begin
              st  <= RX_START;
              cnt <= DIV_W'(half_reload(32'(div)));
            end
          end
          RX_START: begin
            if (!tick) cnt <= cnt - 1'b1;
            else if (!rxd_s) begin
              st  <= RX_DATA;
              cnt <= DIV_W'(bit_reload(32'(div)));
              idx <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end
          RX_DATA: begin
            if (!tick) cnt <= cnt - 1'b1;
            else begin
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
              idx   <= idx + 1'b1;
              cnt   <= DIV_W'(bit_reload(32'(div)));
              if (idx == IDX_W'(DATA_W - 1)) st <= RX_STOP;
            end
          end
          default: begin
            if (!tick) cnt <= cnt - 1'b1;
            else       st  <= RX_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart
  import byte_uart_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DIV_W       = 20,
  parameter int          DATA_W      = 8,
  parameter int          MIN_DIV     = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [11:0] ID_PART     = 12'h5A3,
  parameter logic [3:0]  ID_REV      = 4'h2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);
  localparam int WA_W = ADDR_W - 2;

  // Bus decode
  logic [WA_W-1:0] wa;
  logic acc_wr, acc_rd;
  logic wr_data, wr_stat, wr_ctrl, wr_int, wr_div, rd_data;

  assign wa      = paddr[ADDR_W-1:2];
  assign acc_wr  = psel && penable && pwrite;
  assign acc_rd  = psel && penable && !pwrite;
  assign wr_data = acc_wr && (wa == WA_W'(WA_DATA));
  assign wr_stat = acc_wr && (wa == WA_W'(WA_STAT));
  assign wr_ctrl = acc_wr && (wa == WA_W'(WA_CTRL));
  assign wr_int  = acc_wr && (wa == WA_W'(WA_INT));
  assign wr_div  = acc_wr && (wa == WA_W'(WA_DIV));
  assign rd_data = acc_rd && (wa == WA_W'(WA_DATA));

  logic unused_bits;
  assign unused_bits = ^{paddr[1:0], pwdata[31:DIV_W]};

  // Architectural state
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] txbuf, rxbuf;
  logic tx_full, rx_full, tx_ovr, rx_ovr;
  logic int_tx, int_rx;

  // Internal events, named for the checker
  logic baud_ok, tx_run, rx_run, tx_start;
  logic tx_busy, tx_done, rx_busy, rx_done, rxd_s;
  logic tx_irq_en;
  logic [DATA_W-1:0] rx_byte;
  logic clr_txo, clr_rxo;
  logic int_txo, int_rxo;

  assign baud_ok   = div_valid(32'(div), 32'(MIN_DIV));
  assign tx_run    = ctrl.tx_en && baud_ok;
  assign rx_run    = ctrl.rx_en && baud_ok;
  assign tx_start  = tx_full && !tx_busy;
  assign tx_irq_en = ctrl.tx_ie;
  assign clr_txo   = (wr_stat || wr_int) && pwdata[2];
  assign clr_rxo   = (wr_stat || wr_int) && pwdata[3];

  byte_uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(rxd), .q(rxd_s)
  );

  byte_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .run(tx_run), .start(tx_start),
    .data(txbuf), .div(div), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  byte_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .run(rx_run), .rxd_s(rxd_s),
    .div(div), .busy(rx_busy), .done(rx_done), .data(rx_byte)
  );

  // Configuration registers
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl <= '0;
      div  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(pwdata[CTRL_W-1:0]);
      if (wr_div)  div  <= pwdata[DIV_W-1:0];
    end
  end

  // Transmit holding register and its flags
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      txbuf   <= '0;
      tx_full <= 1'b0;
      tx_ovr  <= 1'b0;
    end else begin
      if (wr_data && !tx_full) begin
        txbuf   <= pwdata[DATA_W-1:0];
        tx_full <= 1'b1;
      end else if (tx_done) begin
        tx_full <= 1'b0;
      end
      if (wr_data && tx_full) tx_ovr <= 1'b1;
      else if (clr_txo)       tx_ovr <= 1'b0;
    end
  end

  // Receive holding register and its flags
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rxbuf   <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (rx_done) begin
        rxbuf   <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (rx_done && rx_full && !rd_data) rx_ovr <= 1'b1;
      else if (clr_rxo)                   rx_ovr <= 1'b0;
    end
  end

  // Latched interrupt flags
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      int_tx <= 1'b0;
      int_rx <= 1'b0;
    end else begin
      if (tx_done && ctrl.tx_ie)    int_tx <= 1'b1;
      else if (wr_int && pwdata[0]) int_tx <= 1'b0;
      if (rx_done && ctrl.rx_ie)    int_rx <= 1'b1;
      else if (wr_int && pwdata[1]) int_rx <= 1'b0;
    end
  end

  // Live overrun interrupts
  assign int_txo = tx_ovr && ctrl.txo_ie;
  assign int_rxo = rx_ovr && ctrl.rxo_ie;

  assign irq_tx    = int_tx;
  assign irq_rx    = int_rx;
  assign irq_txovr = int_txo;
  assign irq_rxovr = int_rxo;
  assign irq_any   = int_tx || int_rx || int_txo || int_rxo;

  // Read mux
  always_comb begin
    prdata = '0;
    if (wa == WA_W'(WA_DATA))       prdata[DATA_W-1:0] = rxbuf;
    else if (wa == WA_W'(WA_STAT))  prdata[3:0] = {rx_ovr, tx_ovr, rx_full, tx_full};
    else if (wa == WA_W'(WA_CTRL))  prdata[CTRL_W-1:0] = ctrl;
    else if (wa == WA_W'(WA_INT))   prdata[3:0] = {int_rxo, int_txo, int_rx, int_tx};
    else if (wa == WA_W'(WA_DIV))   prdata[DIV_W-1:0] = div;
    else if (int'(wa) >= WA_ID_FIRST && int'(wa) <= WA_ID_LAST)
      prdata[7:0] = id_byte(int'(wa) - WA_ID_FIRST, ID_PART, ID_REV);
  end
endmodule

// File: rtl/apb_byte_uart_chk.sv
module apb_byte_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_busy,
  input logic tx_done,
  input logic tx_full,
  input logic tx_ovr,
  input logic wr_data,
  input logic rx_done,
  input logic rx_full,
  input logic rx_ovr,
  input logic rd_data,
  input logic rx_busy,
  input logic rx_run,
  input logic baud_ok,
  input logic tx_irq_en,
  input logic irq_tx
);
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd); // R3

  AST_TX_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_full); // R4

  AST_IRQ_TX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tx_done && tx_irq_en)); // R4

  AST_TX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> tx_ovr); // R5

  AST_RX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_data) |=> rx_ovr); // R7

  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |-> !rx_done); // R8

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rx_full); // R9

  AST_BAUD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_ok |=> (!tx_busy && !rx_busy)); // R13
endmodule

bind apb_byte_uart apb_byte_uart_chk u_chk (
  .clk(pclk), .rst_n(presetn), .txd(txd), .tx_busy(tx_busy),
  .tx_done(tx_done), .tx_full(tx_full), .tx_ovr(tx_ovr), .wr_data(wr_data),
  .rx_done(rx_done), .rx_full(rx_full), .rx_ovr(rx_ovr), .rd_data(rd_data),
  .rx_busy(rx_busy), .rx_run(rx_run), .baud_ok(baud_ok),
  .tx_irq_en(tx_irq_en), .irq_tx(irq_tx)
);

// File: tb/apb_byte_uart_test.sv
module apb_byte_uart_test;
  localparam int BD = 16;
  localparam int TRACE_N = 10 * BD;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        rxd = 1'b1;
  logic        txd, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int checks = 0;
  int errors = 0;
  logic trace [TRACE_N];

  always #5 pclk = ~pclk;

  apb_byte_uart #(.ID_PART(12'h5A3), .ID_REV(4'h2)) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    @(negedge pclk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  // Records one frame from its first low sample and decodes it independently
  task automatic capture_tx(output logic [7:0] b, output int start_len, output logic stop);
    int guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin @(negedge pclk); guard++; end
    for (int j = 0; j < TRACE_N; j++) begin trace[j] = txd; @(negedge pclk); end
    start_len = 0;
    while (start_len < TRACE_N && trace[start_len] == 1'b0) start_len++;
    for (int i = 0; i < 8; i++) b[i] = trace[BD * (1 + i) + BD / 2];
    stop = trace[9 * BD + BD / 2];
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge pclk); rxd = 1'b0; idle(BD);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(BD); end
    rxd = stop; idle(BD);
    rxd = 1'b1; idle(2 * BD);
  endtask

  task automatic t_reset;
    check("R1 txd idle", 32'(txd), 32'h1);
    check("R1 irq lines", 32'({irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any}), 32'h0);
    rd_check("R1 status", 12'h004, 32'h0);
    rd_check("R1 control", 12'h008, 32'h0);
    rd_check("R1 intflags", 12'h00C, 32'h0);
    rd_check("R1 divider", 12'h010, 32'h0);
    rd_check("R1 data", 12'h000, 32'h0);
  endtask

  task automatic t_regs;
    wr(12'h008, 32'hFFFF_FFFF);
    rd_check("R2 control width", 12'h008, 32'h7F);
    wr(12'h008, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_check("R2 divider width", 12'h010, 32'hF_FFFF);
  endtask

  task automatic t_bad_divider;
    logic [7:0] b; int sl; logic sb; int lows = 0;
    wr(12'h010, 32'd8);
    wr(12'h008, 32'h03);
    wr(12'h000, 32'h55);
    rd_check("R3 full flag set", 12'h004, 32'h1);
    for (int k = 0; k < 300; k++) begin @(negedge pclk); if (txd !== 1'b1) lows++; end
    check("R13 txd quiet with small divider", 32'(lows), 32'h0);
    send_rx(8'h66, 1'b1);
    rd_check("R13 no receive with small divider", 12'h004, 32'h1);
    fork
      capture_tx(b, sl, sb);
      wr(12'h010, BD);
    join
    check("R13 pending byte sent", 32'(b), 32'h55);
    idle(8);
    rd_check("R4 full clears", 12'h004, 32'h0);
    rd_check("R4 no flag without enable", 12'h00C, 32'h0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] b; int sl; logic sb;
    wr(12'h008, 32'h05);
    fork
      capture_tx(b, sl, sb);
      begin
        wr(12'h000, 32'hA3);
        rd_check("R3 full while sending", 12'h004, 32'h1);
      end
    join
    check("R3 frame byte", 32'(b), 32'hA3);
    check("R3 start bit length", 32'(sl), BD);
    check("R3 stop bit", 32'(sb), 32'h1);
    idle(8);
    rd_check("R4 full clears", 12'h004, 32'h0);
    rd_check("R4 done flag", 12'h00C, 32'h1);
    check("R12 irq_tx and irq_any", 32'({irq_tx, irq_any}), 32'h3);
    wr(12'h00C, 32'h1);
    check("R11 done flag cleared", 32'({irq_tx, irq_any}), 32'h0);
  endtask

  task automatic t_tx_overrun;
    logic [7:0] b; int sl; logic sb; int lows = 0;
    wr(12'h008, 32'h11);
    fork
      capture_tx(b, sl, sb);
      begin
        wr(12'h000, 32'h11);
        wr(12'h000, 32'h22);
        rd_check("R5 overrun flag", 12'h004, 32'h5);
        rd_check("R10 live tx overrun flag", 12'h00C, 32'h4);
        check("R12 irq_txovr", 32'({irq_txovr, irq_any}), 32'h3);
      end
    join
    check("R5 first byte kept", 32'(b), 32'h11);
    for (int k = 0; k < 30 * BD; k++) begin @(negedge pclk); if (txd !== 1'b1) lows++; end
    check("R5 no second frame", 32'(lows), 32'h0);
    rd_check("R5 status after frame", 12'h004, 32'h4);
    wr(12'h008, 32'h01);
    rd_check("R10 enable off hides flag", 12'h00C, 32'h0);
    check("R10 irq_txovr follows enable", 32'(irq_txovr), 32'h0);
    wr(12'h008, 32'h11);
    rd_check("R10 enable on shows flag", 12'h00C, 32'h4);
    wr(12'h004, 32'h3);
    rd_check("R11 read-only bits ignore writes", 12'h004, 32'h4);
    wr(12'h00C, 32'h4);
    rd_check("R11 intflag write clears overrun", 12'h004, 32'h0);
    rd_check("R11 flag gone", 12'h00C, 32'h0);
  endtask

  task automatic t_rx_basic;
    wr(12'h008, 32'h0A);
    send_rx(8'h5A, 1'b1);
    rd_check("R6 receive full", 12'h004, 32'h2);
    rd_check("R6 receive flag", 12'h00C, 32'h2);
    check("R12 irq_rx and irq_any", 32'({irq_rx, irq_any}), 32'h3);
    rd_check("R9 data byte", 12'h000, 32'h5A);
    rd_check("R9 full cleared by read", 12'h004, 32'h0);
    wr(12'h00C, 32'h2);
    check("R11 receive flag cleared", 32'({irq_rx, irq_any}), 32'h0);
  endtask

  task automatic t_rx_overrun;
    wr(12'h008, 32'h22);
    send_rx(8'h01, 1'b1);
    send_rx(8'h02, 1'b1);
    rd_check("R7 overrun and full", 12'h004, 32'hA);
    rd_check("R10 live rx overrun flag", 12'h00C, 32'h8);
    check("R12 irq_rxovr", 32'({irq_rxovr, irq_any}), 32'h3);
    rd_check("R7 newest byte kept", 12'h000, 32'h02);
    wr(12'h004, 32'h8);
    rd_check("R11 status write clears overrun", 12'h004, 32'h0);
  endtask

  task automatic t_rx_ignore;
    wr(12'h008, 32'h01);
    send_rx(8'h77, 1'b1);
    rd_check("R8 receive disabled", 12'h004, 32'h0);
    wr(12'h008, 32'h02);
    send_rx(8'h77, 1'b0);
    rd_check("R8 bad stop discarded", 12'h004, 32'h0);
    send_rx(8'h99, 1'b1);
    rd_check("R8 next frame taken", 12'h000, 32'h99);
  endtask

  task automatic t_id;
    rd_check("R14 id part low", 12'hFE0, 32'hA3);
    rd_check("R14 id rev and part high", 12'hFE4, 32'h25);
    rd_check("R14 id zero word", 12'hFD0, 32'h0);
    wr(12'hFE0, 32'hFF);
    rd_check("R14 id write ignored", 12'hFE0, 32'hA3);
    wr(12'h800, 32'hFFFF_FFFF);
    rd_check("R14 unmapped reads zero", 12'h800, 32'h0);
    rd_check("R14 control untouched", 12'h008, 32'h02);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    presetn = 1'b1;
    idle(2);
    t_reset;
    t_regs;
    t_bad_divider;
    t_tx_basic;
    t_tx_overrun;
    t_rx_basic;
    t_rx_overrun;
    t_rx_ignore;
    t_id;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule